// File: doc/BRIEF.md
# Secure Configuration Policy Controller

This block is a control state machine placed between a device's configuration port and its configuration memory. It records whether the configuration now loaded came from an encrypted stream, and it uses that record to grant or refuse readback, partial reconfiguration and reloads while the device runs. Before an encrypted stream is written, and again when an encrypted configuration is abandoned, it sweeps zeros through every configuration frame, one frame per clock. The cipher core and the integrity hash stay outside the block. The block enables the decryptor and hands it the key only while an encrypted stream is loading. It accepts a pass or fail verdict from the hash before the device is allowed to run.

A key-access attempt from anywhere, or a failed integrity verdict, sends the block into a zeroize phase. In the first cycle of that phase the key is already empty. A full configuration wipe follows, and then the block returns to idle. Every refused request produces a one-cycle `deny` pulse and leaves the phase and the encrypted-mode flag as they were. Phases are visible on `phase`: 0 idle, 1 pre-load wipe, 2 load, 3 integrity check, 4 run, 5 post wipe, 6 zeroize.

Top module: `cfgsec_ctrl`

## Requirements
- R1: After reset `phase` is 0, and `enc_mode`, `key_set`, `mem_we`, `deny`, `rb_gnt`, `pr_gnt` and `dec_en` are 0, with `dec_key` all zeros.
- R2: In phase 0, `load_req` with `load_enc`=0 moves to phase 2 on the next edge with `enc_mode`=0. Each `strm_valid` cycle in phase 2 drives `mem_we`=1, `mem_wdata`=`strm_data` and consecutive `mem_addr` values starting at 0. `strm_last` then moves a plaintext load to phase 4.
- R3: `load_req` with `load_enc`=1 moves to phase 1. Phase 1 writes zeros to addresses 0 through FRAMES-1, one per cycle in rising order. `clear_done` is high only in the cycle of the last frame, and phase 2 follows with `enc_mode`=1.
- R4: In phase 4 with `enc_mode`=0, `rb_req` and `pr_req` each give a one-cycle `rb_gnt` / `pr_gnt` in the cycle after the request. With `enc_mode`=1 both are refused.
- R5: In phase 4, `load_req` (a warm reload) is refused when `enc_mode`=1. When `enc_mode`=0 it is accepted and starts a new load.
- R6: A refused request gives `deny`=1 for exactly one cycle, in the cycle after the request, and leaves `phase` and `enc_mode` unchanged.
- R7: When an encrypted load ends with `strm_last`, the block moves to phase 3. There, `chk_done` with `chk_ok`=1 moves to phase 4, and `chk_done` with `chk_ok`=0 moves to phase 6.
- R8: `key_rd_req` in any phase moves to phase 6 on the next edge, taking priority over any other transition. `key_set` is 0 in phase 6. Phase 6 lasts one cycle and is followed by a full zero wipe in phase 5, then phase 0.
- R9: `dec_en` is 1 and `dec_key` carries the stored key only in phase 2 with `enc_mode`=1; otherwise `dec_key` is zero. A user decrypt request (`udec_req`) is always refused.
- R10: `cfg_abandon` in phase 4 moves to phase 5 when `enc_mode`=1; a full wipe follows, and then phase 0 with `enc_mode`=0. When `enc_mode`=0 it moves to phase 0 directly.
- R11: `key_wr` in phase 0 stores `key_wdata` and sets `key_set`. In any other phase it is refused and the stored key is unchanged.
- R12: `load_req` in any phase other than 0 or 4 is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_req | input | 1 | Request to start a configuration load |
| load_enc | input | 1 | The requested stream is encrypted |
| strm_valid | input | 1 | A stream frame is present on strm_data |
| strm_last | input | 1 | The present frame is the last of the stream |
| strm_data | input | FRAME_W | Frame data (already decrypted when encrypted) |
| chk_done | input | 1 | Integrity hash verdict is ready |
| chk_ok | input | 1 | Integrity hash verdict: 1 pass, 0 fail |
| rb_req | input | 1 | Readback request |
| pr_req | input | 1 | Partial reconfiguration request |
| udec_req | input | 1 | User logic asks to use the decryptor |
| cfg_abandon | input | 1 | Abandon the running configuration |
| key_wr | input | 1 | Write key storage |
| key_wdata | input | KEY_W | Key value to store |
| key_rd_req | input | 1 | Attempt to access key storage |
| mem_we | output | 1 | Configuration memory write enable |
| mem_addr | output | clog2(FRAMES) | Configuration frame address |
| mem_wdata | output | FRAME_W | Configuration frame data |
| clear_done | output | 1 | Last frame of a wipe is being written |
| dec_en | output | 1 | Decryptor enabled |
| dec_key | output | KEY_W | Key to the decryptor, zero unless enabled |
| rb_gnt | output | 1 | Readback granted pulse |
| pr_gnt | output | 1 | Partial reconfiguration granted pulse |
| deny | output | 1 | Request refused pulse |
| enc_mode | output | 1 | Loaded configuration is encrypted |
| key_set | output | 1 | Key storage holds a key |
| phase | output | 3 | Current phase code |

## Verification
The sharpest overlap is a key-access attempt that lands in the same cycle as the last frame of a post wipe, when `clear_done` would otherwise send the block back to idle. The bench raises `key_rd_req` in exactly the cycle where it sees `clear_done`. It requires phase 6 on the next cycle rather than phase 0, and then a second complete wipe. A second overlap comes from the request table. It drives a readback grant and a user decrypt refusal in one cycle, and expects `rb_gnt` and `deny` to pulse together while the phase stays at run.

// File: rtl/cfgsec_pkg.sv
`timescale 1ns/1ps
package cfgsec_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_CLR_PRE  = 3'd1,
        PH_LOAD     = 3'd2,
        PH_CHECK    = 3'd3,
        PH_RUN      = 3'd4,
        PH_CLR_POST = 3'd5,
        PH_ZERO     = 3'd6
    } phase_e;

    // Outcome of the request gate for one cycle
    typedef struct packed {
        logic deny;
        logic rb_ok;
        logic pr_ok;
        logic load_ok;
        logic key_ok;
    } verdict_t;

endpackage

// File: rtl/cfgsec_wiper.sv
`timescale 1ns/1ps
// Frame sweep counter: one frame address per cycle while run is high.
module cfgsec_wiper #(
    parameter int FRAMES = 16,
    localparam int AW = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] LAST_FRAME = AW'(FRAMES - 1);

    logic [AW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) begin
            cnt_d = (cnt_q == LAST_FRAME) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign addr = cnt_q;
    assign last = run && (cnt_q == LAST_FRAME);

    // R3
    wipe_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> cnt_q == '0);

    // R3
    wipe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(cnt_q) != LAST_FRAME) |-> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/cfgsec_keyreg.sv
`timescale 1ns/1ps
// Clearable key storage; a clear request beats a write in the same cycle.
module cfgsec_keyreg #(
    parameter int KEY_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [KEY_W-1:0] wdata,
    input  logic             clr,
    output logic [KEY_W-1:0] key,
    output logic             set
);
    logic [KEY_W-1:0] key_d, key_q;
    logic             set_d, set_q;

    always_comb begin
        key_d = key_q;
        set_d = set_q;
        if (clr) begin
            key_d = '0;
            set_d = 1'b0;
        end else if (wr) begin
            key_d = wdata;
            set_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
            set_q <= 1'b0;
        end else begin
            key_q <= key_d;
            set_q <= set_d;
        end
    end

    assign key = key_q;
    assign set = set_q;

endmodule

// File: rtl/cfgsec_policy.sv
`timescale 1ns/1ps
// Request gate: decides which requests are legal in the present phase.
module cfgsec_policy
    import cfgsec_pkg::*;
(
    input  phase_e   ph,
    input  logic     enc,
    input  logic     load_req,
    input  logic     rb_req,
    input  logic     pr_req,
    input  logic     udec_req,
    input  logic     key_wr,
    output verdict_t vd
);
    logic in_run, in_idle, plain_run;

    always_comb begin
        in_run    = (ph == PH_RUN);
        in_idle   = (ph == PH_IDLE);
        plain_run = in_run && !enc;

        vd.rb_ok   = rb_req && plain_run;
        vd.pr_ok   = pr_req && plain_run;
        vd.load_ok = load_req && (in_idle || plain_run);
        vd.key_ok  = key_wr && in_idle;
        vd.deny    = (rb_req   && !vd.rb_ok)
                  || (pr_req   && !vd.pr_ok)
                  || (load_req && !vd.load_ok)
                  || (key_wr   && !vd.key_ok)
                  || udec_req;
    end

endmodule

// File: rtl/cfgsec_ctrl.sv
`timescale 1ns/1ps
module cfgsec_ctrl
    import cfgsec_pkg::*;
#(
    parameter int FRAMES  = 16,
    parameter int FRAME_W = 32,
    parameter int KEY_W   = 64,
    localparam int AW = $clog2(FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_req,
    input  logic               load_enc,
    input  logic               strm_valid,
    input  logic               strm_last,
    input  logic [FRAME_W-1:0] strm_data,
    input  logic               chk_done,
    input  logic               chk_ok,
    input  logic               rb_req,
    input  logic               pr_req,
    input  logic               udec_req,
    input  logic               cfg_abandon,
    input  logic               key_wr,
    input  logic [KEY_W-1:0]   key_wdata,
    input  logic               key_rd_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [FRAME_W-1:0] mem_wdata,
    output logic               clear_done,
    output logic               dec_en,
    output logic [KEY_W-1:0]   dec_key,
    output logic               rb_gnt,
    output logic               pr_gnt,
    output logic               deny,
    output logic               enc_mode,
    output logic               key_set,
    output logic [2:0]         phase
);
    localparam logic [AW-1:0] LAST_FRAME = AW'(FRAMES - 1);

    typedef struct packed {
        phase_e        ph;
        logic          enc;   // configuration in memory came encrypted
        logic          pend;  // encryption of the load being prepared
        logic [AW-1:0] ld;    // next load frame address
        logic          deny;
        logic          rbg;
        logic          prg;
    } ctl_t;

    ctl_t      r_q, r_d;
    verdict_t  vd;
    logic      wipe_run, wipe_last, zz;
    logic [AW-1:0]    wipe_addr;
    logic [KEY_W-1:0] key_val;

    cfgsec_policy u_policy (
        .ph       (r_q.ph),
        .enc      (r_q.enc),
        .load_req (load_req),
        .rb_req   (rb_req),
        .pr_req   (pr_req),
        .udec_req (udec_req),
        .key_wr   (key_wr),
        .vd       (vd)
    );

    assign wipe_run = (r_q.ph == PH_CLR_PRE) || (r_q.ph == PH_CLR_POST);

    cfgsec_wiper #(.FRAMES(FRAMES)) u_wiper (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wipe_run),
        .addr  (wipe_addr),
        .last  (wipe_last)
    );

    // Security event: key access attempt or rejected integrity verdict
    assign zz = key_rd_req || (r_q.ph == PH_CHECK && chk_done && !chk_ok);

    cfgsec_keyreg #(.KEY_W(KEY_W)) u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (vd.key_ok),
        .wdata (key_wdata),
        .clr   (zz),
        .key   (key_val),
        .set   (key_set)
    );

    always_comb begin
        r_d      = r_q;
        r_d.deny = vd.deny;
        r_d.rbg  = vd.rb_ok;
        r_d.prg  = vd.pr_ok;
        case (r_q.ph)
            PH_IDLE: begin
                if (vd.load_ok) begin
                    r_d.pend = load_enc;
                    r_d.ld   = '0;
                    r_d.ph   = load_enc ? PH_CLR_PRE : PH_LOAD;
                    if (!load_enc) r_d.enc = 1'b0;
                end
            end
            PH_CLR_PRE: begin
                if (wipe_last) begin
                    r_d.ph  = PH_LOAD;
                    r_d.enc = r_q.pend;
                    r_d.ld  = '0;
                end
            end
            PH_LOAD: begin
                if (strm_valid) begin
                    r_d.ld = (r_q.ld == LAST_FRAME) ? '0 : r_q.ld + 1'b1;
                    if (strm_last) r_d.ph = r_q.enc ? PH_CHECK : PH_RUN;
                end
            end
            PH_CHECK: begin
                if (chk_done && chk_ok) r_d.ph = PH_RUN;
            end
            PH_RUN: begin
                if (cfg_abandon) begin
                    r_d.ph = r_q.enc ? PH_CLR_POST : PH_IDLE;
                end else if (vd.load_ok) begin
                    r_d.pend = load_enc;
                    r_d.ld   = '0;
                    r_d.ph   = load_enc ? PH_CLR_PRE : PH_LOAD;
                end
            end
            PH_CLR_POST: begin
                if (wipe_last) begin
                    r_d.ph  = PH_IDLE;
                    r_d.enc = 1'b0;
                end
            end
            PH_ZERO: r_d.ph = PH_CLR_POST;
            default: r_d.ph = PH_IDLE;
        endcase
        if (zz) r_d.ph = PH_ZERO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, enc: 1'b0, pend: 1'b0, ld: '0,
                     deny: 1'b0, rbg: 1'b0, prg: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // Configuration memory port: a wipe overrides stream frames
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (wipe_run) begin
            mem_we   = 1'b1;
            mem_addr = wipe_addr;
        end else if (r_q.ph == PH_LOAD && strm_valid) begin
            mem_we    = 1'b1;
            mem_addr  = r_q.ld;
            mem_wdata = strm_data;
        end
    end

    assign clear_done = wipe_last;
    assign dec_en     = (r_q.ph == PH_LOAD) && r_q.enc;
    assign dec_key    = dec_en ? key_val : '0;
    assign rb_gnt     = r_q.rbg;
    assign pr_gnt     = r_q.prg;
    assign deny       = r_q.deny;
    assign enc_mode   = r_q.enc;
    assign phase      = r_q.ph;

    // R8
    key_grab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_rd_req |=> r_q.ph == PH_ZERO);

    // R8
    zero_then_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_ZERO && !key_rd_req) |=> r_q.ph == PH_CLR_POST);

    // R8
    key_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ph == PH_ZERO |-> !key_set);

    // R7
    check_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ph == PH_CHECK |-> r_q.enc);

    // R4
    grant_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.rbg || r_q.prg) |-> !r_q.enc);

    // R11
    key_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_set) |-> $past(r_q.ph) == PH_IDLE);

endmodule

// File: tb/cfgsec_ctrl_test.sv
`timescale 1ns/1ps
module cfgsec_ctrl_test;
    localparam int FR = 16;
    localparam int FW = 32;
    localparam int KW = 64;
    localparam int AW = $clog2(FR);
    localparam logic [KW-1:0] KEY_A = 64'hC0DE_5EED_1234_ABCD;
    localparam logic [KW-1:0] KEY_B = 64'h0F0F_F0F0_5A5A_A5A5;

    // {enc, rb, pr, warm, udec, exp_deny, exp_rb_gnt, exp_pr_gnt}
    localparam int NV = 12;
    localparam logic [7:0] VEC [NV] = '{
        8'b0100_0010, 8'b0010_0001, 8'b0110_0011, 8'b0000_1100,
        8'b0100_1110, 8'b0000_0000,
        8'b1100_0100, 8'b1010_0100, 8'b1001_0100, 8'b1000_1100,
        8'b1000_0000, 8'b1111_0100
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_req = 0, load_enc = 0, strm_valid = 0, strm_last = 0;
    logic [FW-1:0] strm_data = '0;
    logic chk_done = 0, chk_ok = 0, rb_req = 0, pr_req = 0, udec_req = 0;
    logic cfg_abandon = 0, key_wr = 0, key_rd_req = 0;
    logic [KW-1:0] key_wdata = '0;
    logic mem_we, clear_done, dec_en, rb_gnt, pr_gnt, deny, enc_mode, key_set;
    logic [AW-1:0] mem_addr;
    logic [FW-1:0] mem_wdata;
    logic [KW-1:0] dec_key;
    logic [2:0] phase;

    int errs = 0;
    int checks = 0;
    bit fin = 0;

    always #2.5 clk = ~clk;

    cfgsec_ctrl #(.FRAMES(FR), .FRAME_W(FW), .KEY_W(KW)) uut (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_enc(load_enc),
        .strm_valid(strm_valid), .strm_last(strm_last), .strm_data(strm_data),
        .chk_done(chk_done), .chk_ok(chk_ok), .rb_req(rb_req), .pr_req(pr_req),
        .udec_req(udec_req), .cfg_abandon(cfg_abandon), .key_wr(key_wr),
        .key_wdata(key_wdata), .key_rd_req(key_rd_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .clear_done(clear_done),
        .dec_en(dec_en), .dec_key(dec_key), .rb_gnt(rb_gnt), .pr_gnt(pr_gnt),
        .deny(deny), .enc_mode(enc_mode), .key_set(key_set), .phase(phase)
    );

    task automatic chkv(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        load_req = 0; load_enc = 0; strm_valid = 0; strm_last = 0;
        chk_done = 0; chk_ok = 0; rb_req = 0; pr_req = 0; udec_req = 0;
        cfg_abandon = 0; key_wr = 0; key_rd_req = 0;
    endtask

    // Expects to be called at a negedge while a wipe phase is active.
    task automatic wipe_walk(string req, bit strike_last);
        int bad = 0;
        for (int k = 0; k < FR; k++) begin
            #1;
            if (!mem_we || mem_addr != AW'(k) || mem_wdata != '0 ||
                clear_done != (k == FR - 1)) bad++;
            if (strike_last && k == FR - 1) key_rd_req = 1;
            @(negedge clk);
            key_rd_req = 0;
        end
        chkv(req, "wipe frames mismatched", 64'(bad), 64'd0);
    endtask

    task automatic stream(string req, int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            strm_valid = 1; strm_last = (i == n - 1); strm_data = FW'(32'hA500 + i);
            #1;
            if (!mem_we || mem_addr != AW'(i) || mem_wdata != FW'(32'hA500 + i)) bad++;
            @(negedge clk);
        end
        strm_valid = 0; strm_last = 0;
        chkv(req, "stream frame writes", 64'(bad), 64'd0);
    endtask

    task automatic plain_to_run();
        load_req = 1; load_enc = 0;
        @(negedge clk); quiet();
        chkv("R2", "phase after plain load_req", 64'(phase), 64'd2);
        chkv("R2", "enc_mode plain", 64'(enc_mode), 64'd0);
        stream("R2", 4);
        chkv("R2", "phase after plain last", 64'(phase), 64'd4);
    endtask

    task automatic enc_to_check(logic [KW-1:0] kexp);
        load_req = 1; load_enc = 1;
        @(negedge clk); quiet();
        chkv("R3", "phase after encrypted load_req", 64'(phase), 64'd1);
        wipe_walk("R3", 0);
        chkv("R3", "phase after pre wipe", 64'(phase), 64'd2);
        chkv("R3", "enc_mode latched", 64'(enc_mode), 64'd1);
        chkv("R9", "dec_en in encrypted load", 64'(dec_en), 64'd1);
        chkv("R9", "dec_key in encrypted load", 64'(dec_key), 64'(kexp));
        stream("R7", 3);
        chkv("R7", "phase after encrypted last", 64'(phase), 64'd3);
    endtask

    task automatic walk(bit sel);
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][7] == sel) begin
                rb_req = VEC[i][6]; pr_req = VEC[i][5];
                load_req = VEC[i][4]; load_enc = VEC[i][4];
                udec_req = VEC[i][3];
                @(negedge clk); quiet();
                chkv("R6", $sformatf("vec%0d deny", i), 64'(deny), 64'(VEC[i][2]));
                chkv("R4", $sformatf("vec%0d rb_gnt", i), 64'(rb_gnt), 64'(VEC[i][1]));
                chkv("R4", $sformatf("vec%0d pr_gnt", i), 64'(pr_gnt), 64'(VEC[i][0]));
                chkv("R6", $sformatf("vec%0d phase kept", i), 64'(phase), 64'd4);
                chkv("R6", $sformatf("vec%0d enc_mode kept", i), 64'(enc_mode), 64'(sel));
                @(negedge clk);
                chkv("R6", $sformatf("vec%0d pulses end", i), 64'({deny, rb_gnt, pr_gnt}), 64'd0);
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!fin) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        quiet();
        repeat (3) @(negedge clk);
        // R1 reset state
        chkv("R1", "phase", 64'(phase), 64'd0);
        chkv("R1", "flags", 64'({enc_mode, key_set, mem_we, deny, rb_gnt, pr_gnt, dec_en}), 64'd0);
        chkv("R1", "dec_key", 64'(dec_key), 64'd0);
        rst_n = 1;
        @(negedge clk);

        // R11 key write in idle
        key_wr = 1; key_wdata = KEY_A;
        @(negedge clk); quiet();
        chkv("R11", "key_set after idle write", 64'(key_set), 64'd1);
        chkv("R11", "no deny on idle write", 64'(deny), 64'd0);

        // Plaintext path and table walk
        plain_to_run();
        walk(1'b0);

        // R5 plaintext warm reload accepted
        load_req = 1; load_enc = 0;
        @(negedge clk); quiet();
        chkv("R5", "plain warm reload phase", 64'(phase), 64'd2);
        chkv("R5", "plain warm reload no deny", 64'(deny), 64'd0);
        stream("R5", 1);
        chkv("R5", "back to run", 64'(phase), 64'd4);

        // R10 plaintext abandon goes straight to idle
        cfg_abandon = 1;
        @(negedge clk); quiet();
        chkv("R10", "plain abandon phase", 64'(phase), 64'd0);

        // Encrypted path, R12 load_req refused during load
        load_req = 1; load_enc = 1;
        @(negedge clk); quiet();
        wipe_walk("R3", 0);
        chkv("R3", "enc load phase", 64'(phase), 64'd2);
        load_req = 1;
        @(negedge clk); quiet();
        chkv("R12", "deny load_req in load", 64'(deny), 64'd1);
        chkv("R12", "phase stays load", 64'(phase), 64'd2);
        chkv("R9", "key offered in load", 64'(dec_key), 64'(KEY_A));
        stream("R7", 2);
        chkv("R7", "check phase", 64'(phase), 64'd3);
        chk_done = 1; chk_ok = 1;
        @(negedge clk); quiet();
        chkv("R7", "pass to run", 64'(phase), 64'd4);
        chkv("R9", "decryptor closed in run", 64'({dec_en, dec_key}), 64'd0);
        walk(1'b1);

        // R11 key write refused outside idle
        key_wr = 1; key_wdata = KEY_B;
        @(negedge clk); quiet();
        chkv("R11", "deny key write in run", 64'(deny), 64'd1);

        // R10 encrypted abandon wipes then idles
        cfg_abandon = 1;
        @(negedge clk); quiet();
        chkv("R10", "enc abandon phase", 64'(phase), 64'd5);
        load_req = 1;
        #1;
        @(negedge clk); quiet();
        chkv("R12", "deny load_req in post wipe", 64'(deny), 64'd1);
        // one wipe frame used by the refused request: finish the rest
        for (int k = 1; k < FR; k++) @(negedge clk);
        chkv("R10", "idle after post wipe", 64'(phase), 64'd0);
        chkv("R10", "enc_mode cleared", 64'(enc_mode), 64'd0);

        // R11 key unchanged; R7 integrity failure zeroizes
        enc_to_check(KEY_A);
        chk_done = 1; chk_ok = 0;
        @(negedge clk); quiet();
        chkv("R7", "fail to zeroize", 64'(phase), 64'd6);
        chkv("R8", "key gone on fail", 64'(key_set), 64'd0);
        @(negedge clk);
        chkv("R8", "zeroize to post wipe", 64'(phase), 64'd5);
        wipe_walk("R8", 0);
        chkv("R8", "idle after zeroize", 64'(phase), 64'd0);

        // R8 key access during load, then collision on last wipe frame
        key_wr = 1; key_wdata = KEY_B;
        @(negedge clk); quiet();
        load_req = 1; load_enc = 1;
        @(negedge clk); quiet();
        wipe_walk("R3", 0);
        chkv("R9", "new key offered", 64'(dec_key), 64'(KEY_B));
        key_rd_req = 1;
        @(negedge clk); quiet();
        chkv("R8", "key access to zeroize", 64'(phase), 64'd6);
        chkv("R8", "key cleared", 64'({key_set, dec_key}), 64'd0);
        @(negedge clk);
        chkv("R8", "post wipe follows", 64'(phase), 64'd5);
        wipe_walk("R8", 1);
        chkv("R8", "key access beats wipe end", 64'(phase), 64'd6);
        @(negedge clk);
        wipe_walk("R8", 0);
        chkv("R8", "idle at last", 64'(phase), 64'd0);

        fin = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule